// File: doc/BRIEF.md
# System control register block with prescaled event counter

This block is a small memory-mapped peripheral on a plain 32-bit register bus. Software uses it to drive two indicator LEDs, read two debounced-free push-button inputs, keep a free-form 32-bit control word, and read or load two wall-clock style counters that advance at 1 Hz and 100 Hz. It also holds a programmable prescaler: a down-counter that, each time it passes through zero, reloads from a software-set value and bumps a 32-bit event counter.

All tick rates are derived inside the block from the system clock by integer dividers. The system clock frequency and the prescaler tick frequency are parameters; the 100 Hz and 1 Hz rates follow from the system clock. A write is a single-cycle strobe with address and data; a read is combinational from the address, so the read value reflects the state after the most recent clock edge.

Top module: `sysctl_regs`

## Requirements
- R1: A synchronous active-high reset clears the LED register, the control word, the reload value, the down-counter, the event counter, both time counters and the button synchroniser, so every mapped register reads 0 afterwards.
- R2: Offset 0x00 keeps bits [1:0] of a write and drives them on `led_o`; a read returns them in bits [1:0] with all upper bits 0.
- R3: Offset 0x08 returns `btn_i` after a two-flop synchroniser in bits [1:0] (the value present at one edge is readable after the second following edge), upper bits 0; writes to it change nothing.
- R4: Offset 0x4C is a 32-bit control word that reads back exactly the last value written.
- R5: The prescaler tick fires once every CLK_HZ/PS_HZ system cycles; counting edges after reset release from 1, it fires on every edge whose number is a multiple of that divisor.
- R6: On a prescaler tick the down-counter (offset 0x20) decrements by one when nonzero; when it is zero it instead reloads from the reload value (offset 0x1C, value held before the edge) and the event counter (offset 0x18) increments by one on the same tick, wrapping modulo 2^32.
- R7: With a reload value of 0 the down-counter stays at 0 and the event counter increments on every prescaler tick.
- R8: Writes to the down-counter or the event counter replace that register and counting continues from the written value; a write landing on a tick wins over that tick for the written register only. A write to the reload value takes effect at the next reload.
- R9: Offsets 0x10 and 0x14 are 32-bit up-counters advancing once per CLK_HZ and once per CLK_HZ/100 system cycles (edge numbering as in R5), wrapping modulo 2^32; a write loads the written value, winning over a coincident tick.
- R10: A read of any other offset returns 0, and a write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| btn_i | input | 2 | Asynchronous button inputs |
| led_o | output | 2 | LED drive outputs |

## Verification
On every cycle the assertions check the prescaler rules at the state level: decrement when nonzero, reload and event increment at zero, the zero-reload hold, a load by write winning over a tick, and that the upper LED and button bits and every unmapped offset read as zero. What only the bench's scenarios can show is the timing against wall-clock rates: that ticks land on the exact edges the divisors imply, that the example of a reload of 5 starting from 7 increments at the eighth and fourteenth ticks, that the button value arrives two edges late, and that writes to unmapped offsets leave every register intact.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned LED_W  = 2;
    localparam int unsigned BTN_W  = 2;

    // Register byte offsets
    localparam logic [ADDR_W-1:0] OFF_LED  = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_BTN  = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_SEC  = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_CENT = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_EVT  = 12'h018;
    localparam logic [ADDR_W-1:0] OFF_RLD  = 12'h01C;
    localparam logic [ADDR_W-1:0] OFF_DOWN = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h04C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_LED,
        SEL_BTN,
        SEL_SEC,
        SEL_CENT,
        SEL_EVT,
        SEL_RLD,
        SEL_DOWN,
        SEL_CTRL
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] down;
        logic [DATA_W-1:0] events;
    } presc_t;

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_LED:  s = SEL_LED;
            OFF_BTN:  s = SEL_BTN;
            OFF_SEC:  s = SEL_SEC;
            OFF_CENT: s = SEL_CENT;
            OFF_EVT:  s = SEL_EVT;
            OFF_RLD:  s = SEL_RLD;
            OFF_DOWN: s = SEL_DOWN;
            OFF_CTRL: s = SEL_CTRL;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    // One prescaler tick: count down, or reload and bump the event count.
    function automatic presc_t presc_step(input presc_t cur,
                                          input logic [DATA_W-1:0] reload);
        presc_t nxt;
        nxt = cur;
        if (cur.down == '0) begin
            nxt.down   = reload;
            nxt.events = cur.events + 1'b1;
        end else begin
            nxt.down = cur.down - 1'b1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/sysctl_tick_div.sv
module sysctl_tick_div #(
    parameter int unsigned DIV = 5
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_count
            localparam int unsigned CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            assign tick_o = (cnt_q == LAST);

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (tick_o) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sysctl_upcount.sv
module sysctl_upcount #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (tick) begin
            q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/sysctl_sync.sv
module sysctl_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg_q[0] <= '0;
                    else     stg_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg_q[i] <= '0;
                    else     stg_q[i] <= stg_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/sysctl_presc.sv
module sysctl_presc
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_rld,
    input  logic              wr_down,
    input  logic              wr_evt,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] reload_o,
    output logic [DATA_W-1:0] down_o,
    output logic [DATA_W-1:0] events_o
);
    presc_t st_q, st_step, st_d;
    logic [DATA_W-1:0] rld_q;

    always_comb begin
        st_step = tick ? presc_step(st_q, rld_q) : st_q;
        st_d    = st_step;
        if (wr_down) st_d.down   = wdata;
        if (wr_evt)  st_d.events = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            rld_q <= '0;
        end else begin
            st_q <= st_d;
            if (wr_rld) rld_q <= wdata;
        end
    end

    assign reload_o = rld_q;
    assign down_o   = st_q.down;
    assign events_o = st_q.events;
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000,
    parameter int unsigned PS_HZ  = 20_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [BTN_W-1:0]  btn_i,
    output logic [LED_W-1:0]  led_o
);
    localparam int unsigned PS_DIV   = (CLK_HZ / PS_HZ) > 0 ? (CLK_HZ / PS_HZ) : 1;
    localparam int unsigned CENT_DIV = (CLK_HZ / 100) > 0 ? (CLK_HZ / 100) : 1;
    localparam int unsigned SEC_DIV  = CLK_HZ;

    reg_sel_e sel;
    logic ps_tick, cent_tick, sec_tick;
    logic [LED_W-1:0]  led_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [BTN_W-1:0]  btn_s;
    logic [DATA_W-1:0] sec_q, cent_q;
    logic [DATA_W-1:0] reload_q, down_q, events_q;

    assign sel = decode(addr);

    sysctl_tick_div #(.DIV(PS_DIV))   u_ps_div   (.clk(clk), .rst(rst), .tick_o(ps_tick));
    sysctl_tick_div #(.DIV(CENT_DIV)) u_cent_div (.clk(clk), .rst(rst), .tick_o(cent_tick));
    sysctl_tick_div #(.DIV(SEC_DIV))  u_sec_div  (.clk(clk), .rst(rst), .tick_o(sec_tick));

    sysctl_upcount #(.W(DATA_W)) u_sec (
        .clk(clk), .rst(rst), .tick(sec_tick),
        .load(wr_en && sel == SEL_SEC), .load_val(wdata), .q(sec_q)
    );
    sysctl_upcount #(.W(DATA_W)) u_cent (
        .clk(clk), .rst(rst), .tick(cent_tick),
        .load(wr_en && sel == SEL_CENT), .load_val(wdata), .q(cent_q)
    );

    sysctl_presc u_presc (
        .clk(clk), .rst(rst), .tick(ps_tick),
        .wr_rld(wr_en && sel == SEL_RLD),
        .wr_down(wr_en && sel == SEL_DOWN),
        .wr_evt(wr_en && sel == SEL_EVT),
        .wdata(wdata),
        .reload_o(reload_q), .down_o(down_q), .events_o(events_q)
    );

    sysctl_sync #(.W(BTN_W), .STAGES(2)) u_btn_sync (
        .clk(clk), .rst(rst), .din(btn_i), .dout(btn_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            led_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_LED)  led_q  <= wdata[LED_W-1:0];
            if (sel == SEL_CTRL) ctrl_q <= wdata;
        end
    end

    assign led_o = led_q;

    always_comb begin
        case (sel)
            SEL_LED:  rdata = {{(DATA_W-LED_W){1'b0}}, led_q};
            SEL_BTN:  rdata = {{(DATA_W-BTN_W){1'b0}}, btn_s};
            SEL_SEC:  rdata = sec_q;
            SEL_CENT: rdata = cent_q;
            SEL_EVT:  rdata = events_q;
            SEL_RLD:  rdata = reload_q;
            SEL_DOWN: rdata = down_q;
            SEL_CTRL: rdata = ctrl_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk
    import sysctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [LED_W-1:0]  led_o,
    input logic              ps_tick,
    input logic [DATA_W-1:0] reload_q,
    input logic [DATA_W-1:0] down_q,
    input logic [DATA_W-1:0] events_q
);
    logic wr_down, wr_evt, mapped;
    assign wr_down = wr_en && (addr == OFF_DOWN);
    assign wr_evt  = wr_en && (addr == OFF_EVT);
    assign mapped  = (addr == OFF_LED)  || (addr == OFF_BTN)  || (addr == OFF_SEC) ||
                     (addr == OFF_CENT) || (addr == OFF_EVT)  || (addr == OFF_RLD) ||
                     (addr == OFF_DOWN) || (addr == OFF_CTRL);

    // R2
    led_read_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == OFF_LED) |-> (rdata == {{(DATA_W-LED_W){1'b0}}, led_o}));

    // R3
    btn_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == OFF_BTN) |-> (rdata[DATA_W-1:BTN_W] == '0));

    // R6
    down_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (ps_tick && down_q != '0 && !wr_down) |=> (down_q == $past(down_q) - 1'b1));

    // R6
    down_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (ps_tick && down_q == '0 && !wr_down) |=> (down_q == $past(reload_q)));

    // R6
    evt_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (ps_tick && down_q == '0 && !wr_evt) |=> (events_q == $past(events_q) + 1'b1));

    // R7
    zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ps_tick && down_q == '0 && reload_q == '0 && !wr_down) |=> (down_q == '0));

    // R8
    evt_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_evt |=> (events_q == $past(wdata)));

    // R8
    down_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_down |=> (down_q == $past(wdata)));

    // R8
    evt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!ps_tick && !wr_evt) |=> $stable(events_q));

    // R10
    unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> (rdata == '0));
endmodule

bind sysctl_regs sysctl_regs_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .led_o(led_o), .ps_tick(ps_tick),
    .reload_q(reload_q), .down_q(down_q), .events_q(events_q)
);

// File: tb/test_sysctl_regs.sv
`timescale 1ns/1ps
module test_sysctl_regs;
    localparam int unsigned CLK_HZ = 2000;
    localparam int unsigned PS_HZ  = 400;
    localparam int unsigned D_PS   = CLK_HZ / PS_HZ;
    localparam int unsigned D_CENT = CLK_HZ / 100;
    localparam int unsigned D_SEC  = CLK_HZ;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [1:0]  btn;
    logic [1:0]  led;

    int total = 0;
    int bad = 0;
    bit checking = 0;

    always #2 clk = ~clk;

    sysctl_regs #(.CLK_HZ(CLK_HZ), .PS_HZ(PS_HZ)) i_sysctl_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .btn_i(btn), .led_o(led)
    );

    // Behavioural reference state
    int unsigned edge_n;
    bit [1:0]  m_led, m_b1, m_b2;
    bit [31:0] m_ctrl, m_sec, m_cent, m_evt, m_rld, m_down;

    always @(posedge clk) begin
        bit pt, tc, ts;
        bit [31:0] nd, ne;
        if (rst) begin
            edge_n = 0; m_led = 0; m_b1 = 0; m_b2 = 0;
            m_ctrl = 0; m_sec = 0; m_cent = 0; m_evt = 0; m_rld = 0; m_down = 0;
        end else begin
            edge_n++;
            pt = (edge_n % D_PS) == 0;
            tc = (edge_n % D_CENT) == 0;
            ts = (edge_n % D_SEC) == 0;
            m_b2 = m_b1; m_b1 = btn;
            nd = m_down; ne = m_evt;
            if (pt) begin
                if (m_down == 0) begin nd = m_rld; ne = m_evt + 1; end
                else nd = m_down - 1;
            end
            if (wr_en && addr == 12'h020) nd = wdata;
            if (wr_en && addr == 12'h018) ne = wdata;
            m_down = nd; m_evt = ne;
            if (wr_en && addr == 12'h01C) m_rld = wdata;
            if (wr_en && addr == 12'h014) m_cent = wdata; else if (tc) m_cent = m_cent + 1;
            if (wr_en && addr == 12'h010) m_sec = wdata;  else if (ts) m_sec = m_sec + 1;
            if (wr_en && addr == 12'h000) m_led = wdata[1:0];
            if (wr_en && addr == 12'h04C) m_ctrl = wdata;
        end
    end

    function automatic bit [31:0] exp_read(input bit [11:0] a);
        case (a)
            12'h000: return {30'd0, m_led};
            12'h008: return {30'd0, m_b2};
            12'h010: return m_sec;
            12'h014: return m_cent;
            12'h018: return m_evt;
            12'h01C: return m_rld;
            12'h020: return m_down;
            12'h04C: return m_ctrl;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input bit [11:0] a);
        case (a)
            12'h000: return "R2";
            12'h008: return "R3";
            12'h04C: return "R4";
            12'h018, 12'h020: return "R5 R6 R7 R8";
            12'h01C: return "R6 R8";
            12'h010, 12'h014: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input bit [31:0] got, input bit [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", req, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the edge
    always @(posedge clk) begin
        #3;
        if (checking && !rst) begin
            chk(req_of(addr), rdata, exp_read(addr));
            chk("R2 led_o", {30'd0, led}, {30'd0, m_led});
        end
    end

    task automatic wr(input bit [11:0] a, input bit [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
    endtask

    task automatic rd_idle(input bit [11:0] a, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0; addr = a;
        end
    endtask

    task automatic rd_const(input bit [11:0] a, input bit [31:0] exp, input string req);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        checking = 0; rst = 1'b1; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0; checking = 1;
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0; btn = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0; checking = 1;

        // R1: everything zero straight after reset
        rd_const(12'h018, 0, "R1 event counter");
        rd_const(12'h020, 0, "R1 down-counter");
        rd_const(12'h014, 0, "R1 100Hz counter");
        rd_const(12'h010, 0, "R1 1Hz counter");
        rd_const(12'h000, 0, "R1 LED");
        rd_const(12'h01C, 0, "R1 reload");
        rd_const(12'h04C, 0, "R1 control word");

        // R7: zero reload -> event counter every tick
        rd_idle(12'h018, 30);
        rd_idle(12'h020, 12);

        // R2: only two LED bits kept
        wr(12'h000, 32'hFFFF_FFFF);
        rd_const(12'h000, 32'h3, "R2 masked LED read");
        wr(12'h000, 32'h0000_0006);
        rd_const(12'h000, 32'h2, "R2 LED bit pattern");

        // R4: control word read-as-written
        wr(12'h04C, 32'hA5C3_1E70);
        rd_const(12'h04C, 32'hA5C3_1E70, "R4 control word");
        wr(12'h04C, 32'h0F0F_F0F0);
        rd_idle(12'h04C, 2);

        // R10: unmapped offsets read zero, writes touch nothing
        wr(12'h004, 32'hDEAD_BEEF);
        wr(12'h024, 32'h1234_5678);
        wr(12'hFFC, 32'hFFFF_FFFF);
        wr(12'h048, 32'h0000_0003);
        rd_const(12'h004, 0, "R10 unmapped 0x004");
        rd_const(12'hFFC, 0, "R10 unmapped 0xFFC");
        rd_const(12'h04C, 32'h0F0F_F0F0, "R10 control word untouched");
        rd_const(12'h000, 32'h2, "R10 LED untouched");
        rd_idle(12'h01C, 2);

        // R3: synchronised buttons, read-only
        rd_idle(12'h008, 2);
        btn = 2'b10;
        rd_idle(12'h008, 4);
        btn = 2'b01;
        rd_idle(12'h008, 3);
        wr(12'h008, 32'hFFFF_FFFF);
        btn = 2'b11;
        rd_idle(12'h008, 4);
        btn = 2'b00;
        rd_idle(12'h008, 3);

        // R6: reload 5 from a start of 7
        wr(12'h01C, 32'd5);
        wr(12'h020, 32'd7);
        wr(12'h018, 32'd0);
        rd_idle(12'h020, 40);
        rd_idle(12'h018, 40);

        // R8: back-to-back loads, some landing on ticks
        for (int i = 0; i < 12; i++) wr(12'h020, 32'(i % 3));
        rd_idle(12'h020, 20);
        for (int i = 0; i < 12; i++) wr(12'h018, 32'(100 * i));
        rd_idle(12'h018, 20);
        wr(12'h01C, 32'd2);
        rd_idle(12'h020, 30);

        // R6/R7: wrap of the event counter with zero reload
        wr(12'h01C, 32'd0);
        wr(12'h020, 32'd0);
        wr(12'h018, 32'hFFFF_FFFE);
        rd_idle(12'h018, 25);

        // R9: time counters, load and wrap
        wr(12'h014, 32'hFFFF_FFFF);
        rd_idle(12'h014, 60);
        wr(12'h010, 32'd41);
        rd_idle(12'h010, 4100);
        for (int i = 0; i < 25; i++) wr(12'h014, 32'(7 * i));
        rd_idle(12'h014, 45);

        // R1: reset in mid-run
        wr(12'h04C, 32'h5555_AAAA);
        do_reset();
        rd_const(12'h018, 0, "R1 event counter after rerun reset");
        rd_const(12'h04C, 0, "R1 control word after rerun reset");
        rd_const(12'h010, 0, "R1 1Hz counter after rerun reset");
        rd_idle(12'h020, 10);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule